// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Direction Counters

This block predicts the next fetch address for a pipelined processor front end. It is a direct-mapped table: each slot remembers the address of a branch (as a tag), the place that branch last jumped to, and a two-bit saturating direction state. The fetch stage presents its current program counter every cycle. In the same cycle the block reports whether the address matches a stored branch, whether that branch is predicted to jump, and the address to fetch next. That next address is either the stored target or the sequential address four bytes on.

A second port comes from the pipeline stage that resolves branches. For each resolved branch it gives the branch address, whether the branch actually jumped, and where it jumped to. On a match the direction state takes one step toward the actual outcome. A taken branch also refreshes the stored target. A taken branch that misses claims its slot, displacing whatever was there. A not-taken branch that misses leaves the table alone.

The direction state is a four-state machine. Its states, with their two-bit codes, are STRONG_NT (0), WEAK_NT (1), WEAK_T (2) and STRONG_T (3). A taken outcome moves it one code up: STRONG_NT to WEAK_NT, WEAK_NT to WEAK_T, WEAK_T to STRONG_T, and STRONG_T stays where it is. A not-taken outcome moves it one code down, in the reverse order, and STRONG_NT stays where it is. A newly allocated slot starts in WEAK_T.

Top module: `branch_target_buffer`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses until a taken update allocates a slot; this also holds after a reset applied mid-run.
- R2: On a miss, pred_hit and pred_taken are 0 and pred_next_pc equals fetch_pc + 4.
- R3: The slot index is pc[IDX_W+1:2] with IDX_W = log2(ENTRIES), and the tag is pc[ADDR_W-1:IDX_W+2]. Bits 1:0 take no part in matching, so fetch_pc values that differ only in those bits give the same hit and target.
- R4: A taken update that misses allocates its slot in WEAK_T (code 2) with the given target. A following lookup of that address gives hit = 1, taken = 1 and next = target.
- R5: A not-taken update that misses changes nothing, and a following lookup of that address still misses.
- R6: On a hit, a taken outcome moves the direction state one code up, saturating at STRONG_T (3). A not-taken outcome moves it one code down, saturating at STRONG_NT (0).
- R7: On a hit the prediction is taken exactly when the direction code is 2 or 3. pred_next_pc is the stored target when the prediction is taken and fetch_pc + 4 when it is not.
- R8: A taken update that hits replaces the stored target. A not-taken update that hits keeps the stored target, whatever upd_target carries.
- R9: A taken update whose address has the same index but a different tag replaces the resident slot, so the old branch misses afterwards. A not-taken update of that kind leaves the resident slot intact.
- R10: The lookup is combinational on the current contents. An update written at a clock edge is seen by lookups from the cycle after that edge. A lookup in the same cycle as the update sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; updates are written on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all valid bits |
| fetch_pc | input | ADDR_W | Address being fetched this cycle |
| pred_hit | output | 1 | fetch_pc matches a valid slot |
| pred_taken | output | 1 | Hit, and the direction code is 2 or 3 |
| pred_next_pc | output | ADDR_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = jumped |
| upd_target | input | ADDR_W | Actual jump destination |

## Verification
The bench builds the block with ADDR_W = 16 and ENTRIES = 4. With these values the index is bits 3:2 and the tag is bits 15:4, so addresses 0x0100 and 0x0200 share slot 0, and the conflict-replacement and no-allocation rules can be reached with short sequences. The small width also keeps the tables readable. A single resident address is walked through every direction code, including both saturation points, while the target-rewrite rule is checked along the way. The two-bit width is a fixed part of the state machine, so no parameter changes it.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // Two-bit direction state; code value is the saturating count.
    typedef enum logic [1:0] {
        STRONG_NT = 2'd0,
        WEAK_NT   = 2'd1,
        WEAK_T    = 2'd2,
        STRONG_T  = 2'd3
    } dir_state_e;

    localparam dir_state_e ALLOC_STATE = WEAK_T;
    localparam int unsigned FALLTHROUGH_BYTES = 4;

endpackage

// File: rtl/btb_dir_fsm.sv
module btb_dir_fsm
    import btb_pkg::*;
(
    input  dir_state_e cur_state,
    input  logic       outcome_taken,
    output dir_state_e next_state,
    output logic       predicts_taken
);

    // Transition process
    always_comb begin
        next_state = cur_state;
        unique case (cur_state)
            STRONG_NT: next_state = outcome_taken ? WEAK_NT  : STRONG_NT;
            WEAK_NT:   next_state = outcome_taken ? WEAK_T   : STRONG_NT;
            WEAK_T:    next_state = outcome_taken ? STRONG_T : WEAK_NT;
            STRONG_T:  next_state = outcome_taken ? STRONG_T : WEAK_T;
        endcase
    end

    // Output process
    always_comb begin
        predicts_taken = 1'b0;
        unique case (cur_state)
            STRONG_NT, WEAK_NT: predicts_taken = 1'b0;
            WEAK_T, STRONG_T:   predicts_taken = 1'b1;
        endcase
    end

endmodule

// File: rtl/btb_slot.sv
module btb_slot
    import btb_pkg::*;
#(
    parameter int unsigned TAG_W  = 12,
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_target,
    input  dir_state_e        wr_state,
    output logic              slot_valid,
    output logic [TAG_W-1:0]  slot_tag,
    output logic [ADDR_W-1:0] slot_target,
    output dir_state_e        slot_state
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_valid  <= 1'b0;
            slot_tag    <= '0;
            slot_target <= '0;
            slot_state  <= STRONG_NT;
        end else if (wr_en) begin
            slot_valid  <= 1'b1;
            slot_tag    <= wr_tag;
            slot_target <= wr_target;
            slot_state  <= wr_state;
        end
    end

endmodule

// File: rtl/btb_update_ctl.sv
module btb_update_ctl
    import btb_pkg::*;
#(
    parameter int unsigned TAG_W  = 12,
    parameter int unsigned ADDR_W = 16
) (
    input  logic              upd_valid,
    input  logic              upd_taken,
    input  logic [TAG_W-1:0]  upd_tag,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              cur_valid,
    input  logic [TAG_W-1:0]  cur_tag,
    input  logic [ADDR_W-1:0] cur_target,
    input  dir_state_e        cur_state,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_target,
    output dir_state_e        wr_state
);

    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_STEP,
        ACT_ALLOC
    } upd_action_e;

    upd_action_e action;
    dir_state_e  stepped_state;
    logic        unused_pred;

    btb_dir_fsm u_step (
        .cur_state      (cur_state),
        .outcome_taken  (upd_taken),
        .next_state     (stepped_state),
        .predicts_taken (unused_pred)
    );

    always_comb begin
        action = ACT_IDLE;
        if (upd_valid) begin
            if (cur_valid && (cur_tag == upd_tag))
                action = ACT_STEP;
            else if (upd_taken)
                action = ACT_ALLOC;
        end
    end

    always_comb begin
        wr_en     = 1'b0;
        wr_target = cur_target;
        wr_state  = cur_state;
        unique case (action)
            ACT_IDLE: begin
                wr_en = 1'b0;
            end
            ACT_STEP: begin
                wr_en     = 1'b1;
                wr_state  = stepped_state;
                wr_target = upd_taken ? upd_target : cur_target;
            end
            ACT_ALLOC: begin
                wr_en     = 1'b1;
                wr_state  = ALLOC_STATE;
                wr_target = upd_target;
            end
            default: wr_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
    import btb_pkg::*;
#(
    parameter int unsigned TAG_W  = 12,
    parameter int unsigned ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic [TAG_W-1:0]  fetch_tag,
    input  logic              rd_valid,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [ADDR_W-1:0] rd_target,
    input  dir_state_e        rd_state,
    output logic              hit,
    output logic              taken,
    output logic [ADDR_W-1:0] next_pc
);

    logic       dir_taken;
    dir_state_e unused_next;

    btb_dir_fsm u_pred (
        .cur_state      (rd_state),
        .outcome_taken  (1'b0),
        .next_state     (unused_next),
        .predicts_taken (dir_taken)
    );

    always_comb begin
        hit     = rd_valid && (rd_tag == fetch_tag);
        taken   = hit && dir_taken;
        next_pc = taken ? rd_target : (fetch_pc + ADDR_W'(FALLTHROUGH_BYTES));
    end

endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer
    import btb_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned ENTRIES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              pred_hit,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_next_pc,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);

    localparam int unsigned IDX_W = $clog2(ENTRIES);
    localparam int unsigned IDX_LO = 2;
    localparam int unsigned TAG_LO = IDX_W + IDX_LO;
    localparam int unsigned TAG_W = ADDR_W - TAG_LO;

    logic [IDX_W-1:0] fetch_idx, upd_idx;
    logic [TAG_W-1:0] fetch_tag, upd_tag;

    assign fetch_idx = fetch_pc[TAG_LO-1:IDX_LO];
    assign fetch_tag = fetch_pc[ADDR_W-1:TAG_LO];
    assign upd_idx   = upd_pc[TAG_LO-1:IDX_LO];
    assign upd_tag   = upd_pc[ADDR_W-1:TAG_LO];

    logic                          slot_valid  [ENTRIES];
    logic [TAG_W-1:0]              slot_tag    [ENTRIES];
    logic [ADDR_W-1:0]             slot_target [ENTRIES];
    dir_state_e                    slot_state  [ENTRIES];

    logic              wr_en;
    logic [ADDR_W-1:0] wr_target;
    dir_state_e        wr_state;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        btb_slot #(
            .TAG_W  (TAG_W),
            .ADDR_W (ADDR_W)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (wr_en && (upd_idx == IDX_W'(g))),
            .wr_tag      (upd_tag),
            .wr_target   (wr_target),
            .wr_state    (wr_state),
            .slot_valid  (slot_valid[g]),
            .slot_tag    (slot_tag[g]),
            .slot_target (slot_target[g]),
            .slot_state  (slot_state[g])
        );
    end

    btb_update_ctl #(
        .TAG_W  (TAG_W),
        .ADDR_W (ADDR_W)
    ) u_upd (
        .upd_valid  (upd_valid),
        .upd_taken  (upd_taken),
        .upd_tag    (upd_tag),
        .upd_target (upd_target),
        .cur_valid  (slot_valid[upd_idx]),
        .cur_tag    (slot_tag[upd_idx]),
        .cur_target (slot_target[upd_idx]),
        .cur_state  (slot_state[upd_idx]),
        .wr_en      (wr_en),
        .wr_target  (wr_target),
        .wr_state   (wr_state)
    );

    btb_lookup #(
        .TAG_W  (TAG_W),
        .ADDR_W (ADDR_W)
    ) u_look (
        .fetch_pc  (fetch_pc),
        .fetch_tag (fetch_tag),
        .rd_valid  (slot_valid[fetch_idx]),
        .rd_tag    (slot_tag[fetch_idx]),
        .rd_target (slot_target[fetch_idx]),
        .rd_state  (slot_state[fetch_idx]),
        .hit       (pred_hit),
        .taken     (pred_taken),
        .next_pc   (pred_next_pc)
    );

endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned ENTRIES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              pred_hit,
    input logic              pred_taken,
    input logic [ADDR_W-1:0] pred_next_pc,
    input logic              upd_valid,
    input logic [ADDR_W-1:0] upd_pc,
    input logic              upd_taken,
    input logic [ADDR_W-1:0] upd_target
);

    logic [ADDR_W-1:0] unused_tgt;
    assign unused_tgt = upd_target;

    p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !pred_hit);

    p_miss_fallthrough_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> (!pred_taken && pred_next_pc == fetch_pc + ADDR_W'(4)));

    p_taken_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> pred_hit);

    p_alloc_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) |=> ((fetch_pc != $past(upd_pc)) || pred_hit));

    p_no_alloc_on_nt_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && !pred_hit && fetch_pc == upd_pc)
            |=> ((fetch_pc != $past(fetch_pc)) || !pred_hit));

endmodule

bind branch_target_buffer btb_checker #(
    .ADDR_W  (ADDR_W),
    .ENTRIES (ENTRIES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_pc     (fetch_pc),
    .pred_hit     (pred_hit),
    .pred_taken   (pred_taken),
    .pred_next_pc (pred_next_pc),
    .upd_valid    (upd_valid),
    .upd_pc       (upd_pc),
    .upd_taken    (upd_taken),
    .upd_target   (upd_target)
);

// File: tb/sim_branch_target_buffer.sv
module sim_branch_target_buffer;

    localparam int unsigned AW = 16;
    localparam int unsigned NE = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic          pred_hit, pred_taken;
    logic [AW-1:0] pred_next_pc;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic          upd_taken = 1'b0;
    logic [AW-1:0] upd_target = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    branch_target_buffer #(.ADDR_W(AW), .ENTRIES(NE)) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target)
    );

    typedef struct packed {
        logic [3:0]    req;
        logic          uv;
        logic [AW-1:0] upc;
        logic          ut;
        logic [AW-1:0] utg;
        logic [AW-1:0] lpc;
        logic          eh;
        logic          et;
        logic [AW-1:0] enx;
    } row_t;

    localparam int NROWS = 20;
    // A=0x0100 (slot 0), B=0x0200 (slot 0, other tag), C=0x0104 (slot 1)
    localparam row_t ROWS [NROWS] = '{
        '{4'd5, 1'b1, 16'h0100, 1'b0, 16'h0F00, 16'h0100, 1'b0, 1'b0, 16'h0104}, // R5
        '{4'd4, 1'b1, 16'h0100, 1'b1, 16'h0800, 16'h0100, 1'b1, 1'b1, 16'h0800}, // R4 code 2
        '{4'd6, 1'b1, 16'h0100, 1'b1, 16'h0800, 16'h0100, 1'b1, 1'b1, 16'h0800}, // R6 code 3
        '{4'd6, 1'b1, 16'h0100, 1'b1, 16'h0800, 16'h0100, 1'b1, 1'b1, 16'h0800}, // R6 sat 3
        '{4'd6, 1'b1, 16'h0100, 1'b0, 16'h0F00, 16'h0100, 1'b1, 1'b1, 16'h0800}, // R6 code 2
        '{4'd7, 1'b1, 16'h0100, 1'b0, 16'h0F00, 16'h0100, 1'b1, 1'b0, 16'h0104}, // R7 code 1
        '{4'd7, 1'b1, 16'h0100, 1'b0, 16'h0F00, 16'h0100, 1'b1, 1'b0, 16'h0104}, // R7 code 0
        '{4'd6, 1'b1, 16'h0100, 1'b0, 16'h0F00, 16'h0100, 1'b1, 1'b0, 16'h0104}, // R6 sat 0
        '{4'd6, 1'b1, 16'h0100, 1'b1, 16'h0A00, 16'h0100, 1'b1, 1'b0, 16'h0104}, // R6 code 1
        '{4'd8, 1'b1, 16'h0100, 1'b1, 16'h0A00, 16'h0100, 1'b1, 1'b1, 16'h0A00}, // R8 new target
        '{4'd6, 1'b1, 16'h0100, 1'b1, 16'h0A00, 16'h0100, 1'b1, 1'b1, 16'h0A00}, // R6 code 3
        '{4'd8, 1'b1, 16'h0100, 1'b0, 16'h0F00, 16'h0100, 1'b1, 1'b1, 16'h0A00}, // R8 target kept
        '{4'd9, 1'b1, 16'h0200, 1'b0, 16'h0E00, 16'h0100, 1'b1, 1'b1, 16'h0A00}, // R9 nt conflict
        '{4'd3, 1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0200, 1'b0, 1'b0, 16'h0204}, // R3 tag differs
        '{4'd9, 1'b1, 16'h0200, 1'b1, 16'h0C00, 16'h0200, 1'b1, 1'b1, 16'h0C00}, // R9 replace
        '{4'd9, 1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0100, 1'b0, 1'b0, 16'h0104}, // R9 old evicted
        '{4'd3, 1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0203, 1'b1, 1'b1, 16'h0C00}, // R3 low bits
        '{4'd2, 1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0104, 1'b0, 1'b0, 16'h0108}, // R2 miss
        '{4'd4, 1'b1, 16'h0104, 1'b1, 16'h0300, 16'h0104, 1'b1, 1'b1, 16'h0300}, // R4 other slot
        '{4'd9, 1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0200, 1'b1, 1'b1, 16'h0C00}  // R9 slot 0 intact
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_pred(input string req, input logic h, input logic t,
                              input logic [AW-1:0] nx);
        check(req, int'(pred_hit), int'(h));
        check(req, int'(pred_taken), int'(t));
        check(req, int'(pred_next_pc), int'(nx));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, everything misses
        fetch_pc = 16'h0100; #1 check_pred("R1", 1'b0, 1'b0, 16'h0104);
        fetch_pc = 16'h0200; #1 check_pred("R1", 1'b0, 1'b0, 16'h0204);
        rst_n = 1'b1;
        @(negedge clk);
        fetch_pc = 16'hFFFC; #1 check_pred("R1 R2 wrap", 1'b0, 1'b0, 16'h0000);

        for (int i = 0; i < NROWS; i++) begin
            @(negedge clk);
            upd_valid  = ROWS[i].uv;
            upd_pc     = ROWS[i].upc;
            upd_taken  = ROWS[i].ut;
            upd_target = ROWS[i].utg;
            fetch_pc   = ROWS[i].upc;
            @(negedge clk);
            upd_valid = 1'b0;
            fetch_pc  = ROWS[i].lpc;
            #1 check_pred($sformatf("R%0d row %0d", ROWS[i].req, i),
                          ROWS[i].eh, ROWS[i].et, ROWS[i].enx);
        end

        // R10: same-cycle lookup sees old contents, next cycle sees the write
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = 16'h0108; upd_taken = 1'b1; upd_target = 16'h0440;
        fetch_pc = 16'h0108;
        #1 check_pred("R10 same cycle", 1'b0, 1'b0, 16'h010C);
        @(negedge clk);
        upd_valid = 1'b0;
        #1 check_pred("R10 next cycle", 1'b1, 1'b1, 16'h0440);

        // R1: reset mid-run clears allocated slots
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        fetch_pc = 16'h0200;
        #1 check_pred("R1 mid-run", 1'b0, 1'b0, 16'h0204);
        fetch_pc = 16'h0108;
        #1 check_pred("R1 mid-run", 1'b0, 1'b0, 16'h010C);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule